// File: doc/BRIEF.md
# Gate-Level Trust Label Propagation Library

This block is a small library of logic primitives in which every data bit carries a one-bit trust label. A label of 1 means untrusted and 0 means trusted. The library has an inverter, two-input AND and OR gates, a 2:1 selector and a register with a synchronous active-low reset. Each primitive produces an output value and an output label.

The labels are exact rather than pessimistic. An output is marked untrusted only if some change to its untrusted inputs could change the output value. A trusted controlling input therefore shields the output from untrusted inputs on the other pins: a trusted 0 on an AND input, a trusted 1 on an OR input, or a trusted select. Untrusted data does not spread to every output it reaches.

The top level places LANES independent copies of each combinational primitive side by side. It also holds a one-bit toggle counter built from the same parts. That counter shows that a trusted reset returns a register to a trusted state, even after it has held untrusted data.

Top module: `taint_track_top`

## Requirements
- R1: For the inverter lane, the output value is the complement of the input value and the output label equals the input label.
- R2: For AND, a trusted 0 on either input gives a trusted 0 output, whatever the other input's value or label.
- R3: For AND, the output label is a·bu + b·au + au·bu. So an untrusted input with the other input at trusted 1 gives an untrusted output, and two untrusted inputs always give an untrusted output.
- R4: For OR, a trusted 1 on either input gives a trusted 1 output, whatever the other input.
- R5: For OR, the output label is ~a·bu + ~b·au + au·bu.
- R6: When all inputs of a combinational primitive are trusted, its output is trusted and its value is the ordinary Boolean result.
- R7: For the selector with a trusted select, the output takes the value and label of d1 when the select is 1 and of d0 when it is 0.
- R8: For the selector with an untrusted select, the output is trusted only when both data inputs are trusted and equal. The output value still follows the select.
- R9: Every combinational output label is 1 exactly when some assignment of new values to that primitive's untrusted inputs changes its output value.
- R10: A clock edge with rst_n low sets the counter to a trusted 0, regardless of its previous value and label and of the load and seed inputs.
- R11: With a trusted load at 1, the counter captures the seed value and label. With a trusted load at 0, the counter inverts its value and keeps its label.
- R12: With an untrusted load, the next counter state has the value selected by load, and its label follows R8 with d0 = inverted current state and d1 = seed.
- R13: After a reset that follows an untrusted state, the counter holds trusted values while it toggles under a trusted load of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counter register |
| rst_n | input | 1 | Synchronous active-low reset, treated as trusted |
| inv_a | input | LANES | Inverter input values |
| inv_a_u | input | LANES | Inverter input labels |
| inv_y | output | LANES | Inverter output values |
| inv_y_u | output | LANES | Inverter output labels |
| and_a | input | LANES | AND first input values |
| and_a_u | input | LANES | AND first input labels |
| and_b | input | LANES | AND second input values |
| and_b_u | input | LANES | AND second input labels |
| and_y | output | LANES | AND output values |
| and_y_u | output | LANES | AND output labels |
| or_a | input | LANES | OR first input values |
| or_a_u | input | LANES | OR first input labels |
| or_b | input | LANES | OR second input values |
| or_b_u | input | LANES | OR second input labels |
| or_y | output | LANES | OR output values |
| or_y_u | output | LANES | OR output labels |
| mux_s | input | LANES | Selector select values (1 picks d1) |
| mux_s_u | input | LANES | Selector select labels |
| mux_d0 | input | LANES | Selector d0 values |
| mux_d0_u | input | LANES | Selector d0 labels |
| mux_d1 | input | LANES | Selector d1 values |
| mux_d1_u | input | LANES | Selector d1 labels |
| mux_y | output | LANES | Selector output values |
| mux_y_u | output | LANES | Selector output labels |
| cnt_load | input | 1 | Counter load control value |
| cnt_load_u | input | 1 | Counter load control label |
| cnt_seed | input | 1 | Counter seed value |
| cnt_seed_u | input | 1 | Counter seed label |
| cnt_q | output | 1 | Counter state value |
| cnt_q_u | output | 1 | Counter state label |

## Verification
The combinational primitives hold no state. A wrong label or value equation therefore appears at the outputs in the same cycle as the input pattern that exposes it. A label stuck at untrusted shows up as soon as a trusted controlling input is applied. The counter register is the only stored state. A corrupted value or label there appears at cnt_q and cnt_q_u on the edge after it is written. It then stays wrong until the next load or reset, so a fault in the reset path is seen on the first cycle after reset. Faults in the toggle path persist and are seen on every following edge.

// File: rtl/taint_pkg.sv
// Shared types for label-carrying logic.
// A tracked bit pairs a data value with a trust label; unt = 1 means untrusted.
package taint_pkg;

    typedef struct packed {
        logic val;  // data value
        logic unt;  // 1 = untrusted
    } tbit_t;

    localparam tbit_t TRUSTED_ZERO = '{val: 1'b0, unt: 1'b0};

endpackage

// File: rtl/tt_inv.sv
// Tracked inverter: complements the value, passes the label through.
// Assumes nothing about its input; purely combinational.
module tt_inv
    import taint_pkg::*;
(
    input  tbit_t a,
    output tbit_t y
);

    assign y.val = ~a.val;
    assign y.unt = a.unt;

    // R1 check: output value differs from input and the label is not altered
    always_comb begin
        if (!$isunknown(a)) begin
            a_r1_inv_behaviour: assert ((y.val != a.val) && (y.unt == a.unt))
                else $error("R1 inverter mismatch");
        end
    end

endmodule

// File: rtl/tt_and2.sv
// Tracked two-input AND. The label is exact: a trusted 0 on one input
// masks the other input entirely. Purely combinational.
module tt_and2
    import taint_pkg::*;
(
    input  tbit_t a,
    input  tbit_t b,
    output tbit_t y
);

    logic a_masks;
    logic b_masks;
    logic both_open;

    // Identify which input can steer the output on its own
    always_comb begin
        a_masks   = b.val & a.unt;
        b_masks   = a.val & b.unt;
        both_open = a.unt & b.unt;
    end

    assign y.val = a.val & b.val;
    assign y.unt = a_masks | b_masks | both_open;

    // R2, R3, R6 checks on the output pair
    always_comb begin
        if (!$isunknown({a, b})) begin
            a_r2_and_zero_masks: assert (!(((!a.val) && (!a.unt)) || ((!b.val) && (!b.unt)))
                                         || ((!y.val) && (!y.unt)))
                else $error("R2 trusted zero did not mask");
            a_r3_and_both_untrusted: assert (!(a.unt && b.unt) || y.unt)
                else $error("R3 two untrusted inputs gave trusted output");
            a_r6_and_all_trusted: assert (a.unt || b.unt || !y.unt)
                else $error("R6 trusted inputs gave untrusted output");
        end
    end

endmodule

// File: rtl/tt_or2.sv
// Tracked two-input OR. The label is exact: a trusted 1 on one input
// masks the other input entirely. Purely combinational.
module tt_or2
    import taint_pkg::*;
(
    input  tbit_t a,
    input  tbit_t b,
    output tbit_t y
);

    logic a_masks;
    logic b_masks;
    logic both_open;

    // Identify which input can steer the output on its own
    always_comb begin
        a_masks   = (~b.val) & a.unt;
        b_masks   = (~a.val) & b.unt;
        both_open = a.unt & b.unt;
    end

    assign y.val = a.val | b.val;
    assign y.unt = a_masks | b_masks | both_open;

    // R4, R5, R6 checks on the output pair
    always_comb begin
        if (!$isunknown({a, b})) begin
            a_r4_or_one_masks: assert (!((a.val && !a.unt) || (b.val && !b.unt))
                                       || (y.val && !y.unt))
                else $error("R4 trusted one did not mask");
            a_r5_or_both_untrusted: assert (!(a.unt && b.unt) || y.unt)
                else $error("R5 two untrusted inputs gave trusted output");
            a_r6_or_all_trusted: assert (a.unt || b.unt || !y.unt)
                else $error("R6 trusted inputs gave untrusted output");
        end
    end

endmodule

// File: rtl/tt_mux2.sv
// Tracked 2:1 selector (s = 1 picks d1). The value is built from tracked
// inverter, AND and OR cells. The label is exact: the composed gate label
// over-taints when an untrusted select chooses between equal trusted data,
// so the output label uses a dedicated term that the composed label bounds.
module tt_mux2
    import taint_pkg::*;
(
    input  tbit_t s,
    input  tbit_t d0,
    input  tbit_t d1,
    output tbit_t y
);

    tbit_t s_n;
    tbit_t take1;
    tbit_t take0;
    tbit_t merged;
    logic  sel_unt_label;
    logic  sel_trusted_label;

    tt_inv  u_sinv  (.a(s),     .y(s_n));
    tt_and2 u_take1 (.a(s),     .b(d1),    .y(take1));
    tt_and2 u_take0 (.a(s_n),   .b(d0),    .y(take0));
    tt_or2  u_merge (.a(take1), .b(take0), .y(merged));

    // Exact label: an untrusted select matters only if the data could differ
    always_comb begin
        sel_unt_label     = d0.unt | d1.unt | (d0.val ^ d1.val);
        sel_trusted_label = s.val ? d1.unt : d0.unt;
    end

    assign y.val = merged.val;
    assign y.unt = s.unt ? sel_unt_label : sel_trusted_label;

    // R7, R8 checks; also the exact label never exceeds the composed one
    always_comb begin
        if (!$isunknown({s, d0, d1})) begin
            a_r7_mux_trusted_select: assert (s.unt || (y == (s.val ? d1 : d0)))
                else $error("R7 trusted select did not pass the chosen input");
            a_r8_mux_equal_data: assert (!(s.unt && !d0.unt && !d1.unt && (d0.val == d1.val))
                                         || (!y.unt && (y.val == d0.val)))
                else $error("R8 equal trusted data tainted by select");
            a_r9_mux_bounded: assert (!y.unt || merged.unt)
                else $error("R9 exact label exceeds composed label");
        end
    end

endmodule

// File: rtl/tt_reg.sv
// Tracked register: stores a value with its label on each rising edge.
// Synchronous active-low reset, assumed trusted, loads a trusted 0.
module tt_reg
    import taint_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  tbit_t d,
    output tbit_t q
);

    // Capture value and label together, or clear to trusted zero
    always_ff @(posedge clk) begin
        if (!rst_n) q <= TRUSTED_ZERO;
        else        q <= d;
    end

    // R10: the first cycle out of reset shows a trusted zero
    a_r10_reset_trusted_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q == TRUSTED_ZERO))
        else $error("R10 reset did not leave a trusted zero");

endmodule

// File: rtl/tt_toggle.sv
// One-bit toggle counter built from tracked cells. With load = 0 the state
// inverts each cycle; with load = 1 it captures the seed. Assumes rst_n is
// asserted before the first use of the state.
module tt_toggle
    import taint_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  tbit_t load,
    input  tbit_t seed,
    output tbit_t q
);

    tbit_t q_n;
    tbit_t next_q;

    tt_inv  u_flip (.a(q), .y(q_n));
    tt_mux2 u_pick (.s(load), .d0(q_n), .d1(seed), .y(next_q));
    tt_reg  u_state(.clk(clk), .rst_n(rst_n), .d(next_q), .q(q));

    // R11: a trusted idle load toggles the value and keeps the label
    a_r11_toggle_keeps_label: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load.val) && !$past(load.unt))
        |-> ((q.val != $past(q.val)) && (q.unt == $past(q.unt))))
        else $error("R11 toggle changed label or held value");

    // R13: a trusted state toggled by a trusted load stays trusted
    a_r13_trusted_stays: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(q.unt) && !$past(load.unt) && !$past(load.val))
        |-> !q.unt)
        else $error("R13 trusted toggling became untrusted");

endmodule

// File: rtl/taint_track_top.sv
// Top of the label-propagation library: LANES parallel copies of the
// inverter, AND, OR and selector, plus one tracked toggle counter.
// Labels use 1 = untrusted. rst_n is synchronous, active low, trusted.
module taint_track_top
    import taint_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] inv_a,
    input  logic [LANES-1:0] inv_a_u,
    output logic [LANES-1:0] inv_y,
    output logic [LANES-1:0] inv_y_u,
    input  logic [LANES-1:0] and_a,
    input  logic [LANES-1:0] and_a_u,
    input  logic [LANES-1:0] and_b,
    input  logic [LANES-1:0] and_b_u,
    output logic [LANES-1:0] and_y,
    output logic [LANES-1:0] and_y_u,
    input  logic [LANES-1:0] or_a,
    input  logic [LANES-1:0] or_a_u,
    input  logic [LANES-1:0] or_b,
    input  logic [LANES-1:0] or_b_u,
    output logic [LANES-1:0] or_y,
    output logic [LANES-1:0] or_y_u,
    input  logic [LANES-1:0] mux_s,
    input  logic [LANES-1:0] mux_s_u,
    input  logic [LANES-1:0] mux_d0,
    input  logic [LANES-1:0] mux_d0_u,
    input  logic [LANES-1:0] mux_d1,
    input  logic [LANES-1:0] mux_d1_u,
    output logic [LANES-1:0] mux_y,
    output logic [LANES-1:0] mux_y_u,
    input  logic             cnt_load,
    input  logic             cnt_load_u,
    input  logic             cnt_seed,
    input  logic             cnt_seed_u,
    output logic             cnt_q,
    output logic             cnt_q_u
);

    localparam int LAST_LANE = LANES - 1;

    // One set of primitives per lane
    for (genvar ln = 0; ln <= LAST_LANE; ln++) begin : g_lane
        tbit_t ia, iy, aa, ab, ay, oa, ob, oy, ms, m0, m1, my;

        assign ia = '{val: inv_a[ln], unt: inv_a_u[ln]};
        assign aa = '{val: and_a[ln], unt: and_a_u[ln]};
        assign ab = '{val: and_b[ln], unt: and_b_u[ln]};
        assign oa = '{val: or_a[ln],  unt: or_a_u[ln]};
        assign ob = '{val: or_b[ln],  unt: or_b_u[ln]};
        assign ms = '{val: mux_s[ln],  unt: mux_s_u[ln]};
        assign m0 = '{val: mux_d0[ln], unt: mux_d0_u[ln]};
        assign m1 = '{val: mux_d1[ln], unt: mux_d1_u[ln]};

        tt_inv  u_inv (.a(ia), .y(iy));
        tt_and2 u_and (.a(aa), .b(ab), .y(ay));
        tt_or2  u_or  (.a(oa), .b(ob), .y(oy));
        tt_mux2 u_mux (.s(ms), .d0(m0), .d1(m1), .y(my));

        assign inv_y[ln]   = iy.val;
        assign inv_y_u[ln] = iy.unt;
        assign and_y[ln]   = ay.val;
        assign and_y_u[ln] = ay.unt;
        assign or_y[ln]    = oy.val;
        assign or_y_u[ln]  = oy.unt;
        assign mux_y[ln]   = my.val;
        assign mux_y_u[ln] = my.unt;
    end

    tbit_t c_load, c_seed, c_q;

    assign c_load = '{val: cnt_load, unt: cnt_load_u};
    assign c_seed = '{val: cnt_seed, unt: cnt_seed_u};

    tt_toggle u_cnt (.clk(clk), .rst_n(rst_n), .load(c_load), .seed(c_seed), .q(c_q));

    assign cnt_q   = c_q.val;
    assign cnt_q_u = c_q.unt;

endmodule

// File: tb/test_taint_track_top.sv
`timescale 1ns/1ps
module test_taint_track_top;

    localparam int LANES = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LANES-1:0] inv_a = '0, inv_a_u = '0, inv_y, inv_y_u;
    logic [LANES-1:0] and_a = '0, and_a_u = '0, and_b = '0, and_b_u = '0, and_y, and_y_u;
    logic [LANES-1:0] or_a = '0, or_a_u = '0, or_b = '0, or_b_u = '0, or_y, or_y_u;
    logic [LANES-1:0] mux_s = '0, mux_s_u = '0, mux_d0 = '0, mux_d0_u = '0;
    logic [LANES-1:0] mux_d1 = '0, mux_d1_u = '0, mux_y, mux_y_u;
    logic cnt_load = 1'b0, cnt_load_u = 1'b0, cnt_seed = 1'b0, cnt_seed_u = 1'b0;
    logic cnt_q, cnt_q_u;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic exp_q, exp_qu;

    always #2.5 clk = ~clk;

    taint_track_top #(.LANES(LANES)) i_taint_track_top (
        .clk, .rst_n,
        .inv_a, .inv_a_u, .inv_y, .inv_y_u,
        .and_a, .and_a_u, .and_b, .and_b_u, .and_y, .and_y_u,
        .or_a, .or_a_u, .or_b, .or_b_u, .or_y, .or_y_u,
        .mux_s, .mux_s_u, .mux_d0, .mux_d0_u, .mux_d1, .mux_d1_u, .mux_y, .mux_y_u,
        .cnt_load, .cnt_load_u, .cnt_seed, .cnt_seed_u, .cnt_q, .cnt_q_u
    );

    // Reference: {value, label}; label = some change of untrusted inputs alters output
    function automatic logic [1:0] ref_gate(bit is_or, logic a, logic au, logic b, logic bu);
        logic y = is_or ? (a | b) : (a & b);
        logic t = 1'b0;
        for (int ia = 0; ia < 2; ia++) begin
            for (int ib = 0; ib < 2; ib++) begin
                logic va = 1'(ia);
                logic vb = 1'(ib);
                if ((au || va == a) && (bu || vb == b)) begin
                    if ((is_or ? (va | vb) : (va & vb)) != y) t = 1'b1;
                end
            end
        end
        return {y, t};
    endfunction

    function automatic logic [1:0] ref_mux(logic s, logic su, logic d0, logic d0u,
                                           logic d1, logic d1u);
        logic y = s ? d1 : d0;
        logic t = 1'b0;
        for (int is = 0; is < 2; is++) begin
            for (int i0 = 0; i0 < 2; i0++) begin
                for (int i1 = 0; i1 < 2; i1++) begin
                    logic vs = 1'(is);
                    logic v0 = 1'(i0);
                    logic v1 = 1'(i1);
                    if ((su || vs == s) && (d0u || v0 == d0) && (d1u || v1 == d1)) begin
                        if ((vs ? v1 : v0) != y) t = 1'b1;
                    end
                end
            end
        end
        return {y, t};
    endfunction

    task automatic check(string req, logic [2*LANES-1:0] got, logic [2*LANES-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Apply one combinational pattern and check every primitive against the reference
    task automatic comb_case(string req);
        logic [LANES-1:0] ev, eu;
        #1;
        for (int l = 0; l < LANES; l++) {ev[l], eu[l]} = {~inv_a[l], inv_a_u[l]};
        check({req, " R1 inv"}, {inv_y, inv_y_u}, {ev, eu});
        for (int l = 0; l < LANES; l++)
            {ev[l], eu[l]} = ref_gate(1'b0, and_a[l], and_a_u[l], and_b[l], and_b_u[l]);
        check({req, " R2/R3 R9 and"}, {and_y, and_y_u}, {ev, eu});
        for (int l = 0; l < LANES; l++)
            {ev[l], eu[l]} = ref_gate(1'b1, or_a[l], or_a_u[l], or_b[l], or_b_u[l]);
        check({req, " R4/R5 R9 or"}, {or_y, or_y_u}, {ev, eu});
        for (int l = 0; l < LANES; l++)
            {ev[l], eu[l]} = ref_mux(mux_s[l], mux_s_u[l], mux_d0[l], mux_d0_u[l],
                                     mux_d1[l], mux_d1_u[l]);
        check({req, " R7/R8 R9 mux"}, {mux_y, mux_y_u}, {ev, eu});
    endtask

    // One counter cycle: drive at negedge, model the edge, check after it
    task automatic cnt_step(string req, logic rn, logic ld, logic ldu, logic sd, logic sdu);
        logic [1:0] nx;
        @(negedge clk);
        rst_n = rn; cnt_load = ld; cnt_load_u = ldu; cnt_seed = sd; cnt_seed_u = sdu;
        if (!rn) nx = 2'b00;
        else     nx = ref_mux(ld, ldu, ~exp_q, exp_qu, sd, sdu);
        @(posedge clk);
        #1;
        {exp_q, exp_qu} = nx;
        n_tests++;
        if ({cnt_q, cnt_q_u} !== {exp_q, exp_qu}) begin
            n_fail++;
            $display("FAIL %s counter: got %b%b expected %b%b", req, cnt_q, cnt_q_u, exp_q, exp_qu);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4757));
        exp_q = 1'b0; exp_qu = 1'b0;
        repeat (3) @(negedge clk);
        cnt_step("R10 reset state", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R6: everything trusted
        @(negedge clk);
        inv_a = 4'b1010; inv_a_u = '0;
        and_a = 4'b1100; and_b = 4'b1010; and_a_u = '0; and_b_u = '0;
        or_a  = 4'b1100; or_b  = 4'b1010; or_a_u = '0; or_b_u = '0;
        mux_s = 4'b0101; mux_s_u = '0; mux_d0 = 4'b0011; mux_d1 = 4'b1001;
        mux_d0_u = '0; mux_d1_u = '0;
        comb_case("R6 all trusted");

        // R2/R4: trusted controlling value masks untrusted partner
        @(negedge clk);
        and_a = 4'b0000; and_a_u = 4'b0000; and_b = 4'b1010; and_b_u = 4'b1111;
        or_a  = 4'b1111; or_a_u  = 4'b0000; or_b  = 4'b0101; or_b_u  = 4'b1111;
        inv_a_u = 4'b0110;
        comb_case("R2 R4 masking");

        // R3/R5: trusted non-controlling value or both untrusted
        @(negedge clk);
        and_a = 4'b1111; and_a_u = 4'b0011; and_b = 4'b0101; and_b_u = 4'b1111;
        or_a  = 4'b0000; or_a_u  = 4'b0011; or_b  = 4'b0101; or_b_u  = 4'b1111;
        comb_case("R3 R5 untrusted spread");

        // R7/R8: select cases
        @(negedge clk);
        mux_s = 4'b1010; mux_s_u = 4'b0000; mux_d0 = 4'b0110; mux_d0_u = 4'b1100;
        mux_d1 = 4'b0101; mux_d1_u = 4'b0011;
        comb_case("R7 trusted select");
        @(negedge clk);
        mux_s = 4'b1010; mux_s_u = 4'b1111; mux_d0 = 4'b1100; mux_d1 = 4'b1010;
        mux_d0_u = 4'b0000; mux_d1_u = 4'b0000;
        comb_case("R8 untrusted select");
        @(negedge clk);
        mux_d0 = 4'b1111; mux_d1 = 4'b1111; mux_d0_u = 4'b0010; mux_d1_u = 4'b0100;
        comb_case("R8 untrusted select equal data");

        // R9: random patterns against the exhaustive reference
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            {inv_a, inv_a_u, and_a, and_a_u} = 16'($urandom);
            {and_b, and_b_u, or_a, or_a_u}   = 16'($urandom);
            {or_b, or_b_u, mux_s, mux_s_u}   = 16'($urandom);
            {mux_d0, mux_d0_u, mux_d1, mux_d1_u} = 16'($urandom);
            comb_case("R9 random");
        end

        // R11, R13: counter directed run
        cnt_step("R11 load untrusted seed", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        cnt_step("R11 toggle untrusted", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        cnt_step("R11 toggle untrusted", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        cnt_step("R10 reset from untrusted", 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 4; k++) cnt_step("R13 trusted toggling", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        cnt_step("R11 load trusted seed", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        cnt_step("R12 untrusted load idle", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);

        // R12: random counter steps with occasional reset
        for (int k = 0; k < 200; k++) begin
            logic [4:0] r = 5'($urandom);
            cnt_step("R12 random", (k % 37) != 0, r[0], r[1] & r[4], r[2], r[3]);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule